// File: doc/BRIEF.md
# Serial Unlock Pattern Detector

This block sits beside a byte-wide memory and watches the stream of bus accesses, each presented as a one-cycle read or write strobe with a single data bit. It grants access to a hidden timekeeping function only after a fixed 64-bit key has arrived, one bit per write, in the right order. Until that happens every access goes to the memory, including the writes that carry the key. System software should therefore aim its key writes at a spare scratch location.

A read arms the detector and moves its compare pointer to the first key bit. Each armed write whose data bit equals the key bit under the pointer moves the pointer on by one. A wrong bit freezes the pointer, and every later write is ignored until the next read starts a fresh search. When the last bit matches, the grant rises. The memory is then deselected for a window of accesses, which ends after a fixed count or on a transfer-done pulse. An external reset request aborts the search or the window unless a mask input tells the block to ignore it.

Top module: `serial_unlock_det`

## Requirements
- R1: After `rst_n` is released, `clk_grant` is 0 and the detector is unarmed.
- R2: The key is the bytes C5, 3A, A3, 5C, C5, 3A, A3, 5C in that order, each sent least significant bit first on `wr_bit`. After a read, 64 writes carrying these bits raise `clk_grant` in the cycle after the 64th write.
- R3: While `clk_grant` is 0, `mem_sel` is 1 in exactly the cycles that carry a read or write strobe. This includes the key writes.
- R4: Writes that arrive with no read since reset, since the last grant or since the last abort do not advance recognition: a full key sent then gives no grant.
- R5: A write with a wrong bit freezes the pointer, and all later writes are ignored until a read. Sending the correct bits afterwards gives no grant.
- R6: A read while recognition is under way restarts it from key bit 0. After the read, only a complete key grants.
- R7: While `clk_grant` is 1, `mem_sel` stays 0. The grant drops in the cycle after the 64th access of the window. Reads inside the window do not arm a new search.
- R8: A `xfer_done` pulse while granted clears `clk_grant` in the next cycle. A new read is needed before the next unlock.
- R9: With `ext_rst_mask` at 0, a low `ext_rst_n` aborts recognition and clears the grant in the next cycle.
- R10: With `ext_rst_mask` at 1, `ext_rst_n` has no effect on recognition or on the grant.
- R11: A cycle with both strobes high counts as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_bit | input | 1 | Data bit 0 of the access |
| xfer_done | input | 1 | Ends the transfer window early |
| ext_rst_n | input | 1 | External abort request, active low |
| ext_rst_mask | input | 1 | 1 = ignore `ext_rst_n` |
| clk_grant | output | 1 | Timekeeping access granted |
| mem_sel | output | 1 | Access routed to main memory |

## Verification
`mem_sel` is combinational and is due in the same cycle as its strobe. `clk_grant` is registered: it changes in the cycle after the completing write, the 64th window access, the done pulse or the abort. The driver applies each cycle's inputs at the falling edge and records the expected grant and select for that cycle. The monitor compares them 1 ns before the next rising edge, so every check sees the grant left by the previous edge together with the select for the strobes of the current cycle.

// File: rtl/unlock_pkg.sv
package unlock_pkg;
  localparam int KEY_BITS = 64;
  // byte 0 sits in bits 7:0, sent LSB first
  localparam logic [KEY_BITS-1:0] KEY_DEFAULT = 64'h5CA3_3AC5_5CA3_3AC5;
  localparam int WINDOW_DEFAULT = 64;

  function automatic int ptr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/ukey_tracker.sv
module ukey_tracker #(
  parameter int KEY_LEN = 64,
  parameter logic [KEY_LEN-1:0] KEY = '0,
  parameter int PW = unlock_pkg::ptr_width(KEY_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          abort,
  input  logic          hold,
  input  logic          rd,
  input  logic          wr,
  input  logic          din,
  output logic [PW-1:0] ptr,
  output logic          armed,
  output logic          miss,
  output logic          unlock
);
  logic wr_only, cmp_ok, at_last;

  assign wr_only = wr & ~rd;
  assign cmp_ok  = (din == KEY[ptr]);
  assign at_last = (ptr == PW'(KEY_LEN - 1));
  assign unlock  = ~abort & ~hold & wr_only & armed & ~miss & cmp_ok & at_last;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      ptr   <= '0;
      armed <= 1'b0;
      miss  <= 1'b0;
    end else if (!hold) begin
      if (rd) begin
        ptr   <= '0;
        armed <= 1'b1;
        miss  <= 1'b0;
      end else if (wr && armed && !miss) begin
        if (!cmp_ok) begin
          miss <= 1'b1;
        end else if (at_last) begin
          ptr   <= '0;
          armed <= 1'b0;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uxfer_window.sv
module uxfer_window #(
  parameter int XFER_LEN = 64,
  parameter int CW = unlock_pkg::ptr_width(XFER_LEN)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic unlock,
  input  logic access,
  input  logic done,
  output logic grant,
  output logic win_end
);
  logic [CW-1:0] cnt;
  logic          at_end;

  assign at_end  = (cnt == CW'(XFER_LEN - 1));
  assign win_end = grant & ~abort & ~done & access & at_end;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      grant <= 1'b0;
      cnt   <= '0;
    end else if (!grant) begin
      grant <= unlock;
      cnt   <= '0;
    end else if (done) begin
      grant <= 1'b0;
      cnt   <= '0;
    end else if (access) begin
      if (at_end) begin
        grant <= 1'b0;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/serial_unlock_det.sv
module serial_unlock_det #(
  parameter int KEY_LEN = unlock_pkg::KEY_BITS,
  parameter logic [KEY_LEN-1:0] KEY = unlock_pkg::KEY_DEFAULT,
  parameter int XFER_LEN = unlock_pkg::WINDOW_DEFAULT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic xfer_done,
  input  logic ext_rst_n,
  input  logic ext_rst_mask,
  output logic clk_grant,
  output logic mem_sel
);
  localparam int PTR_W = unlock_pkg::ptr_width(KEY_LEN);

  logic             abort_evt, access_evt, unlock_evt, window_end;
  logic [PTR_W-1:0] key_ptr;
  logic             key_armed, key_miss;

  assign abort_evt  = ~ext_rst_n & ~ext_rst_mask;
  assign access_evt = rd_stb | wr_stb;
  assign mem_sel    = access_evt & ~clk_grant;

  ukey_tracker #(.KEY_LEN(KEY_LEN), .KEY(KEY), .PW(PTR_W)) u_track (
    .clk(clk), .rst_n(rst_n), .abort(abort_evt), .hold(clk_grant),
    .rd(rd_stb), .wr(wr_stb), .din(wr_bit),
    .ptr(key_ptr), .armed(key_armed), .miss(key_miss), .unlock(unlock_evt)
  );

  uxfer_window #(.XFER_LEN(XFER_LEN)) u_win (
    .clk(clk), .rst_n(rst_n), .abort(abort_evt), .unlock(unlock_evt),
    .access(access_evt), .done(xfer_done),
    .grant(clk_grant), .win_end(window_end)
  );
endmodule

// File: rtl/ukey_checker.sv
module ukey_checker #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_stb,
  input logic          xfer_done,
  input logic          clk_grant,
  input logic          mem_sel,
  input logic          unlock_evt,
  input logic          abort_evt,
  input logic          window_end,
  input logic [PW-1:0] key_ptr,
  input logic          armed,
  input logic          miss_flag
);
  assert_mem_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clk_grant |-> !mem_sel);

  assert_window_close_R7: assert property (@(posedge clk) disable iff (!rst_n)
    window_end |=> !clk_grant);

  assert_unlock_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
    unlock_evt |=> clk_grant);

  assert_abort_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (!clk_grant && !armed && key_ptr == '0));

  assert_miss_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_flag && !clk_grant && !rd_stb && !abort_evt) |=> ($stable(key_ptr) && miss_flag));

  assert_read_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !clk_grant && !abort_evt) |=> (armed && !miss_flag && key_ptr == '0));

  assert_unarmed_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !rd_stb) |=> key_ptr == '0);

  assert_done_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_grant && xfer_done) |=> (!clk_grant && !armed));
endmodule

bind serial_unlock_det ukey_checker #(.PW(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .xfer_done(xfer_done),
  .clk_grant(clk_grant), .mem_sel(mem_sel), .unlock_evt(unlock_evt),
  .abort_evt(abort_evt), .window_end(window_end), .key_ptr(key_ptr),
  .armed(key_armed), .miss_flag(key_miss)
);

// File: tb/serial_unlock_det_tb.sv
module serial_unlock_det_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_stb = 0, wr_stb = 0, wr_bit = 0, xfer_done = 0;
  logic ext_rst_n = 1, ext_rst_mask = 0;
  logic clk_grant, mem_sel;
  int   n_chk = 0, n_fail = 0;
  bit   finished = 0;

  typedef struct { logic g; logic m; string tag; } exp_t;
  exp_t sb[$];

  always #5 clk = ~clk;

  serial_unlock_det u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_bit(wr_bit),
    .xfer_done(xfer_done), .ext_rst_n(ext_rst_n), .ext_rst_mask(ext_rst_mask),
    .clk_grant(clk_grant), .mem_sel(mem_sel)
  );

  function automatic logic key_at(input int i);
    logic [7:0] b;
    case ((i / 8) % 4)
      0: b = 8'hC5;
      1: b = 8'h3A;
      2: b = 8'hA3;
      default: b = 8'h5C;
    endcase
    return b[i % 8];
  endfunction

  // one bus cycle; eg = grant expected during this cycle
  task automatic cyc(input logic r, input logic w, input logic d, input logic dn,
                     input logic xr_n, input logic eg, input string tag);
    exp_t e;
    @(negedge clk);
    rd_stb = r; wr_stb = w; wr_bit = d; xfer_done = dn; ext_rst_n = xr_n;
    e.g = eg; e.m = (r | w) & ~eg; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic send_bits(input int lo, input int hi, input int flip_at, input string tag);
    for (int i = lo; i <= hi; i++)
      cyc(0, 1, key_at(i) ^ (i == flip_at), 0, 1, 0, tag);
  endtask

  task automatic rd(input logic eg, input string tag);
    cyc(1, 0, 0, 0, 1, eg, tag);
  endtask

  task automatic idle(input logic eg, input string tag);
    cyc(0, 0, 0, 0, 1, eg, tag);
  endtask

  // monitor: compare 1 ns before the rising edge
  initial begin
    exp_t e;
    forever begin
      @(negedge clk);
      #4;
      if (sb.size() > 0) begin
        e = sb.pop_front();
        n_chk++;
        if (clk_grant !== e.g) begin
          n_fail++;
          $display("FAIL %s clk_grant actual=%b expected=%b t=%0t", e.tag, clk_grant, e.g, $time);
        end
        n_chk++;
        if (mem_sel !== e.m) begin
          n_fail++;
          $display("FAIL %s mem_sel actual=%b expected=%b t=%0t", e.tag, mem_sel, e.m, $time);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(0, "R1 reset state");
    cyc(0, 1, 1, 0, 1, 0, "R3 unarmed write to memory");
    // R4: key with no read
    send_bits(0, 63, -1, "R4 key without read");
    idle(0, "R4 no grant without read");
    // R2/R3: normal unlock
    rd(0, "R3 read to memory");
    send_bits(0, 63, -1, "R3 key writes to memory");
    idle(1, "R2 grant after key");
    // R7: window of 64 accesses
    for (int k = 0; k < 64; k++) cyc(k[0], ~k[0], 1, 0, 1, 1, "R7 window access");
    cyc(0, 1, 0, 0, 1, 0, "R7 grant drops after window");
    send_bits(0, 63, -1, "R7 window read did not arm");
    idle(0, "R7 no grant without fresh read");
    // R8: done pulse
    rd(0, "R8 arm");
    send_bits(0, 63, -1, "R8 key");
    idle(1, "R8 granted");
    cyc(1, 0, 0, 0, 1, 1, "R8 access in window");
    cyc(0, 0, 0, 1, 1, 1, "R8 done pulse");
    idle(0, "R8 grant cleared by done");
    send_bits(0, 63, -1, "R8 key after done");
    idle(0, "R8 needs new read");
    // R5: mismatch freeze
    rd(0, "R5 arm");
    send_bits(0, 9, -1, "R5 good prefix");
    send_bits(10, 10, 10, "R5 wrong bit");
    send_bits(10, 63, -1, "R5 retry ignored");
    idle(0, "R5 no grant after miss");
    rd(0, "R5 recover");
    send_bits(0, 63, -1, "R5 full key");
    idle(1, "R5 grant after recovery");
    cyc(0, 0, 0, 1, 1, 1, "R8 done");
    // R6: read restarts
    rd(0, "R6 arm");
    send_bits(0, 29, -1, "R6 prefix");
    rd(0, "R6 restart");
    send_bits(30, 63, -1, "R6 tail only");
    idle(0, "R6 tail alone no grant");
    rd(0, "R6 arm");
    send_bits(0, 29, -1, "R6 prefix");
    rd(0, "R6 restart");
    send_bits(0, 63, -1, "R6 full key");
    idle(1, "R6 grant after restart");
    cyc(0, 0, 0, 1, 1, 1, "R8 done");
    // R9: external abort honoured
    rd(0, "R9 arm");
    send_bits(0, 29, -1, "R9 prefix");
    cyc(0, 0, 0, 0, 0, 0, "R9 abort");
    send_bits(30, 63, -1, "R9 tail");
    idle(0, "R9 aborted search");
    rd(0, "R9 arm");
    send_bits(0, 63, -1, "R9 key");
    idle(1, "R9 granted");
    cyc(0, 0, 0, 0, 0, 1, "R9 abort in window");
    idle(0, "R9 grant cleared");
    // R10: abort masked
    ext_rst_mask = 1;
    rd(0, "R10 arm");
    send_bits(0, 29, -1, "R10 prefix");
    cyc(0, 0, 0, 0, 0, 0, "R10 masked abort");
    send_bits(30, 63, -1, "R10 tail");
    idle(1, "R10 grant despite request");
    cyc(0, 0, 0, 0, 0, 1, "R10 masked abort in window");
    idle(1, "R10 grant kept");
    cyc(0, 0, 0, 1, 1, 1, "R8 done");
    ext_rst_mask = 0;
    // R11: both strobes = read
    rd(0, "R11 arm");
    send_bits(0, 62, -1, "R11 prefix");
    cyc(1, 1, key_at(63), 0, 1, 0, "R11 both strobes");
    idle(0, "R11 no grant");
    send_bits(0, 63, -1, "R11 key after combined strobe");
    idle(1, "R11 combined strobe armed");
    cyc(0, 0, 0, 1, 1, 1, "R8 done");
    idle(0, "R8 done");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule